// File: doc/BRIEF.md
# Wide-Access Serial FIFO Data Port

This block connects a 32-bit host register bus to the byte-wide transmit and receive FIFOs of one serial channel. A single bus access moves one to four bytes. A write pushes the enabled bytes into the transmit FIFO. A read pops up to the requested number of bytes from the receive FIFO. Byte lane 0 always carries the oldest byte.

A second read window returns received bytes interleaved with the line-status flags stored with each byte. This lets software unload data and error flags in one transaction. The window is read as one pair (16 bits) or two pairs (32 bits).

A legacy path is also provided. It exposes a byte-only holding register, plus a separate status word that shows the oldest byte's flags without popping it. Each channel instance decodes only its own address region. Burst beats at incrementing addresses inside a 64-byte window all map onto the same FIFO.

The FIFOs sit outside the block. Each is seen through a level or space count, a four-byte peek, and a push or pop strobe that carries a byte count.

Top module: `uart_wide_port`

## Requirements
- R1: With channel parameter C, the block sets ready only for addresses in its own region. These are: the data window at 0x100+0x200*C through +0x3F, the pair window at 0x140+0x200*C through +0x3F, the holding word at 0x200*C, and the status word at 0x200*C+4. Any other address leaves ready low and causes no FIFO action.
- R2: A data-window write with byte enables 0001, 0011, 0111 or 1111 pushes 1, 2, 3 or 4 bytes in one cycle. Lane 0 (wdata[7:0]) is pushed first. The response count equals the number of bytes pushed.
- R3: If the transmit FIFO space is smaller than the write's byte count, ready stays low and nothing is pushed. Once space is sufficient, all bytes are committed in one access.
- R4: A data-window read with byte enables 0001, 0011, 0111 or 1111 pops min(requested, level) bytes. Lane i holds the i-th oldest byte. Lanes beyond the popped count read zero. The response count equals the number popped.
- R5: A pair-window read with byte enables 0011 requests one pair, and 1111 requests two pairs. It returns data0 in [7:0], status0 in [15:8], data1 in [23:16] and status1 in [31:24], and pops min(pairs, level) bytes. Unfilled pairs read zero.
- R6: The holding word accepts byte enable 0001 only. A read pops one byte into [7:0], and a write pushes wdata[7:0]. The status word, read with byte enable 0010, returns the oldest byte's status in [15:8] without popping. It reads zero when the receive FIFO is empty.
- R7: An access inside the region that has any other byte-enable pattern is still acknowledged but has no effect. The same applies to a write to the pair window or the status word. In all these cases nothing is pushed or popped, and the response data and count are zero.
- R8: Push and pop strobes fire in the cycle the access is accepted. The response valid pulse, with its data and count, follows one cycle after acceptance and lasts one cycle.
- R9: Sixteen 32-bit beats at incrementing addresses across the data window move 64 bytes in FIFO order, for reads and for writes.
- R10: After reset, the response valid, data and count outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address |
| be | input | 4 | Byte-lane enables |
| wdata | input | 32 | Write data |
| ready | output | 1 | Access accepted this cycle |
| rvalid | output | 1 | Response valid, one cycle after acceptance |
| rdata | output | 32 | Read response data |
| rcount | output | 3 | Bytes actually moved by the access |
| tx_space | input | LW | Free entries in the transmit FIFO |
| tx_push | output | 1 | Push strobe |
| tx_push_n | output | 3 | Bytes to push |
| tx_push_data | output | 32 | Bytes to push, lane 0 first |
| rx_level | input | LW | Entries in the receive FIFO |
| rx_peek_data | input | 32 | Four oldest received bytes, oldest in [7:0] |
| rx_peek_stat | input | 32 | Status of those four bytes, same lane order |
| rx_pop | output | 1 | Pop strobe |
| rx_pop_n | output | 3 | Bytes to pop |

## Verification
Ready, push and pop are combinational, so the bench reads them between the falling edge where it drives a request and the next rising edge. Read data, count and the valid pulse are registered on the accepting edge. The bench therefore samples them at the falling edge one cycle later, and confirms that valid has dropped at the falling edge after that. The FIFO model in the bench applies push and pop on the accepting edge. As a result, level and queue contents are compared one cycle after acceptance, together with the response.

// File: rtl/uart_wide_port.sv
module uart_wide_port #(
  parameter int CHAN = 0,
  parameter int AW   = 12,
  parameter int LW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [31:0]   rdata,
  output logic [2:0]    rcount,
  input  logic [LW-1:0] tx_space,
  output logic          tx_push,
  output logic [2:0]    tx_push_n,
  output logic [31:0]   tx_push_data,
  input  logic [LW-1:0] rx_level,
  input  logic [31:0]   rx_peek_data,
  input  logic [31:0]   rx_peek_stat,
  output logic          rx_pop,
  output logic [2:0]    rx_pop_n
);
  localparam int REGION = CHAN * 'h200;
  localparam logic [AW-1:0] DWIN = AW'(REGION + 'h100);
  localparam logic [AW-1:0] SWIN = AW'(REGION + 'h140);
  localparam logic [AW-1:0] HOLD = AW'(REGION);
  localparam logic [AW-1:0] LSRW = AW'(REGION + 4);

  logic hit_d, hit_s, hit_h, hit_l, hit_any;
  assign hit_d   = addr[AW-1:6] == DWIN[AW-1:6];
  assign hit_s   = addr[AW-1:6] == SWIN[AW-1:6];
  assign hit_h   = addr[AW-1:2] == HOLD[AW-1:2];
  assign hit_l   = addr[AW-1:2] == LSRW[AW-1:2];
  assign hit_any = hit_d | hit_s | hit_h | hit_l;

  logic [2:0] be_n;
  always_comb begin
    case (be)
      4'b0001: be_n = 3'd1;
      4'b0011: be_n = 3'd2;
      4'b0111: be_n = 3'd3;
      4'b1111: be_n = 3'd4;
      default: be_n = 3'd0;
    endcase
  end

  logic ok_d, ok_s, ok_h, ok_l;
  assign ok_d = hit_d && be_n != 3'd0;
  assign ok_s = hit_s && (be == 4'b0011 || be == 4'b1111);
  assign ok_h = hit_h && be == 4'b0001;
  assign ok_l = hit_l && be == 4'b0010;

  logic [2:0] wr_n, rd_n, avail, got;
  always_comb begin
    wr_n = 3'd0;
    rd_n = 3'd0;
    if (we) begin
      if (ok_d)      wr_n = be_n;
      else if (ok_h) wr_n = 3'd1;
    end else begin
      if (ok_d)      rd_n = be_n;
      else if (ok_s) rd_n = (be == 4'b1111) ? 3'd2 : 3'd1;
      else if (ok_h) rd_n = 3'd1;
    end
  end

  assign avail = (rx_level > LW'(4)) ? 3'd4 : rx_level[2:0];
  assign got   = (rd_n < avail) ? rd_n : avail;

  logic stall;
  assign stall = (wr_n != 3'd0) && (LW'(wr_n) > tx_space);
  assign ready = req && hit_any && !stall;

  assign tx_push      = ready && wr_n != 3'd0;
  assign tx_push_n    = tx_push ? wr_n : 3'd0;
  assign tx_push_data = wdata;
  assign rx_pop       = ready && got != 3'd0;
  assign rx_pop_n     = rx_pop ? got : 3'd0;

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (!we) begin
      if (ok_d) begin
        for (int i = 0; i < 4; i++)
          if (3'(i) < got) rd_next[8*i +: 8] = rx_peek_data[8*i +: 8];
      end else if (ok_s) begin
        for (int j = 0; j < 2; j++)
          if (3'(j) < got) begin
            rd_next[16*j +: 8]     = rx_peek_data[8*j +: 8];
            rd_next[16*j + 8 +: 8] = rx_peek_stat[8*j +: 8];
          end
      end else if (ok_h) begin
        if (got != 3'd0) rd_next[7:0] = rx_peek_data[7:0];
      end else if (ok_l) begin
        if (rx_level != '0) rd_next[15:8] = rx_peek_stat[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rcount <= '0;
    end else begin
      rvalid <= ready;
      if (ready) begin
        rdata  <= rd_next;
        rcount <= we ? wr_n : got;
      end
    end
  end

  a_r3_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> LW'(tx_push_n) <= tx_space);
  a_r4_pop_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> LW'(rx_pop_n) <= rx_level);
  a_r8_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> rvalid);
  a_r8_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !rvalid);
  a_r1_quiet_unless_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!tx_push && !rx_pop));
  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && rx_pop));
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rcount <= 3'd4);
endmodule

// File: tb/sim_uart_wide_port.sv
module sim_uart_wide_port;
  localparam int CH = 3;
  localparam logic [11:0] DW = 12'h700;
  localparam logic [11:0] SW = 12'h740;
  localparam logic [11:0] HW = 12'h600;
  localparam logic [11:0] LS = 12'h604;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic ready, rvalid, tx_push, rx_pop;
  logic [31:0] rdata, tx_push_data;
  logic [2:0] rcount, tx_push_n, rx_pop_n;
  logic [6:0] tx_space, tx_len = '0, rx_level = '0;
  logic [31:0] rx_peek_data = '0, rx_peek_stat = '0;
  int tx_cap = 100;
  assign tx_space = 7'(tx_cap) - tx_len;

  uart_wide_port #(.CHAN(CH), .AW(12), .LW(7)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata),
    .rcount(rcount), .tx_space(tx_space), .tx_push(tx_push),
    .tx_push_n(tx_push_n), .tx_push_data(tx_push_data),
    .rx_level(rx_level), .rx_peek_data(rx_peek_data),
    .rx_peek_stat(rx_peek_stat), .rx_pop(rx_pop), .rx_pop_n(rx_pop_n));

  logic [7:0] txq[$];
  logic [7:0] rxd[$];
  logic [7:0] rxs[$];

  always @(posedge clk) begin
    if (tx_push)
      for (int i = 0; i < int'(tx_push_n); i++) txq.push_back(tx_push_data[8*i +: 8]);
    if (rx_pop)
      for (int i = 0; i < int'(rx_pop_n); i++) begin
        void'(rxd.pop_front());
        void'(rxs.pop_front());
      end
    tx_len   <= 7'(txq.size());
    rx_level <= 7'(rxd.size());
    for (int i = 0; i < 4; i++) begin
      rx_peek_data[8*i +: 8] <= (i < rxd.size()) ? rxd[i] : 8'h00;
      rx_peek_stat[8*i +: 8] <= (i < rxs.size()) ? rxs[i] : 8'h00;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rx_load(input int n, input logic [7:0] seed);
    @(negedge clk);
    rxd.delete();
    rxs.delete();
    for (int i = 0; i < n; i++) begin
      rxd.push_back(8'(seed + 8'(i)));
      rxs.push_back(8'(seed + 8'(i)) ^ 8'h5A);
    end
    @(posedge clk);
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [3:0] b,
                     input logic [31:0] d, output logic [31:0] rd, output logic [2:0] rc);
    int waits = 0;
    @(negedge clk);
    req = 1; we = w; addr = a; be = b; wdata = d;
    #1;
    while (!ready && waits < 20) begin
      @(negedge clk); #1; waits++;
    end
    chk("R8 accepted", 32'(ready), 32'd1);
    @(negedge clk);
    req = 0;
    rd = rdata; rc = rcount;
    chk("R8 rvalid after accept", 32'(rvalid), 32'd1);
    @(negedge clk);
    chk("R8 rvalid one cycle", 32'(rvalid), 32'd0);
  endtask

  localparam logic [11:0] VEC [12] = '{
    {2'd0, 4'b0001, 3'd3, 3'd1},
    {2'd0, 4'b0011, 3'd3, 3'd2},
    {2'd0, 4'b0111, 3'd5, 3'd3},
    {2'd0, 4'b1111, 3'd4, 3'd4},
    {2'd0, 4'b1111, 3'd2, 3'd2},
    {2'd0, 4'b0111, 3'd0, 3'd0},
    {2'd1, 4'b0011, 3'd2, 3'd1},
    {2'd1, 4'b1111, 3'd3, 3'd2},
    {2'd1, 4'b1111, 3'd1, 3'd1},
    {2'd0, 4'b0101, 3'd4, 3'd0},
    {2'd1, 4'b0001, 3'd2, 3'd0},
    {2'd0, 4'b1111, 3'd7, 3'd4}
  };

  bit done = 0;
  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, exp;
    logic [2:0] rc;
    repeat (3) @(negedge clk);
    chk("R10 rvalid reset", 32'(rvalid), 32'd0);
    chk("R10 rdata reset", rdata, 32'd0);
    chk("R10 rcount reset", 32'(rcount), 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      logic [1:0] win;
      logic [3:0] b;
      logic [2:0] ld, ex;
      logic [7:0] seed;
      string tag;
      {win, b, ld, ex} = VEC[v];
      seed = 8'(16 * v + 1);
      rx_load(int'(ld), seed);
      exp = '0;
      for (int i = 0; i < 4; i++)
        if (win == 2'd0 && i < int'(ex)) exp[8*i +: 8] = 8'(seed + 8'(i));
      for (int j = 0; j < 2; j++)
        if (win == 2'd1 && j < int'(ex)) begin
          exp[16*j +: 8]     = 8'(seed + 8'(j));
          exp[16*j + 8 +: 8] = 8'(seed + 8'(j)) ^ 8'h5A;
        end
      tag = (ex == 3'd0 && ld != 3'd0) ? "R7 table" : (win == 2'd1 ? "R5 table" : "R4 table");
      acc(1'b0, win == 2'd1 ? SW : DW, b, 32'd0, rd, rc);
      chk(tag, rd, exp);
      chk(tag, 32'(rc), 32'(ex));
      chk(tag, 32'(rx_level), 32'(ld - ex));
    end

    @(negedge clk); txq.delete();
    acc(1'b1, DW, 4'b0001, 32'h44332211, rd, rc);
    chk("R2 count 1", 32'(rc), 32'd1);
    acc(1'b1, DW + 12'h4, 4'b0111, 32'h88776655, rd, rc);
    chk("R2 count 3", 32'(rc), 32'd3);
    acc(1'b1, DW + 12'h8, 4'b1111, 32'hDDCCBBAA, rd, rc);
    chk("R2 count 4", 32'(rc), 32'd4);
    chk("R2 txq size", 32'(txq.size()), 32'd8);
    chk("R2 order", {txq[3], txq[2], txq[1], txq[0]}, 32'h77665511);
    chk("R2 order hi", {txq[7], txq[6], txq[5], txq[4]}, 32'hDDCCBBAA);

    @(negedge clk);
    tx_cap = txq.size() + 3;
    req = 1; we = 1; addr = DW; be = 4'b1111; wdata = 32'h04030201;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R3 stalled ready", 32'(ready), 32'd0);
      chk("R3 no push while stalled", 32'(tx_push), 32'd0);
      @(negedge clk);
    end
    tx_cap = tx_cap + 1;
    #1;
    chk("R3 ready once space", 32'(ready), 32'd1);
    chk("R8 push in accept cycle", 32'(tx_push), 32'd1);
    chk("R8 push count", 32'(tx_push_n), 32'd4);
    @(negedge clk);
    req = 0;
    chk("R3 whole commit", 32'(txq.size()), 32'd12);
    chk("R3 bytes", {txq[11], txq[10], txq[9], txq[8]}, 32'h04030201);
    chk("R3 rcount", 32'(rcount), 32'd4);
    tx_cap = 100;

    rx_load(4, 8'h30);
    @(negedge clk);
    req = 1; we = 0; addr = 12'h500; be = 4'b1111;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R1 other channel ready", 32'(ready), 32'd0);
      @(negedge clk);
    end
    req = 0;
    chk("R1 other channel no pop", 32'(rx_level), 32'd4);
    acc(1'b0, DW + 12'h3C, 4'b0001, 0, rd, rc);
    chk("R1 data window top", rd, 32'h30);
    acc(1'b0, SW + 12'h3C, 4'b0011, 0, rd, rc);
    chk("R1 pair window top", rd, {16'h0, 8'h31 ^ 8'h5A, 8'h31});

    rx_load(2, 8'hC0);
    acc(1'b0, LS, 4'b0010, 0, rd, rc);
    chk("R6 status word", rd, {16'h0, 8'hC0 ^ 8'h5A, 8'h00});
    chk("R6 status no pop", 32'(rx_level), 32'd2);
    acc(1'b0, HW, 4'b0001, 0, rd, rc);
    chk("R6 holding read", rd, 32'h000000C0);
    chk("R6 holding pops one", 32'(rx_level), 32'd1);
    acc(1'b0, HW, 4'b0011, 0, rd, rc);
    chk("R7 holding wide ignored", rd, 32'd0);
    chk("R7 holding wide no pop", 32'(rx_level), 32'd1);
    @(negedge clk); txq.delete();
    acc(1'b1, HW, 4'b0001, 32'h000000EE, rd, rc);
    chk("R6 holding write", 32'(txq.size() == 1 ? txq[0] : 8'h00), 32'hEE);
    acc(1'b1, SW, 4'b1111, 32'h12345678, rd, rc);
    chk("R7 pair write ignored", 32'(txq.size()), 32'd1);
    chk("R7 pair write count", 32'(rc), 32'd0);
    rx_load(0, 8'h00);
    acc(1'b0, LS, 4'b0010, 0, rd, rc);
    chk("R6 status empty", rd, 32'd0);

    rx_load(64, 8'h40);
    for (int k = 0; k < 16; k++) begin
      acc(1'b0, DW + 12'(4 * k), 4'b1111, 0, rd, rc);
      exp = {8'(8'h43 + 8'(4*k)), 8'(8'h42 + 8'(4*k)), 8'(8'h41 + 8'(4*k)), 8'(8'h40 + 8'(4*k))};
      chk("R9 burst read beat", rd, exp);
    end
    chk("R9 burst drained", 32'(rx_level), 32'd0);
    @(negedge clk); txq.delete();
    for (int k = 0; k < 16; k++)
      acc(1'b1, DW + 12'(4 * k), 4'b1111,
          {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)}, rd, rc);
    chk("R9 burst write size", 32'(txq.size()), 32'd64);
    for (int k = 0; k < 64; k += 9)
      chk("R9 burst write order", 32'(txq[k]), 32'(k));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule